// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host offers one request at a time on a valid/ready handshake: a 17-bit address, a write flag and, for writes, a byte of data. The controller turns each accepted request into a sequence of registered memory strobes. These are an active-low and an active-high chip select, an active-low output enable and an active-low write enable. The sequence meets the RAM's timing when the timing is expressed as whole clock cycles.

Writes keep the output enable high throughout. The data bus driver turns on only after the write strobe has been low for at least one cycle. It stays on for one cycle after the strobe rises, so both data setup and data hold are measured from the edge that ends the write. Reads hold the output enable low for a programmable access time and capture the bus at the end of it. One cycle later they return the byte with a single valid pulse. A turnaround gap follows so that the RAM has released the bus before any later write can drive it. Between requests both chip selects sit in the deselected state.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While `req_ready_o` is high the memory is deselected: `mem_ce1_n_o`=1, `mem_ce2_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_dq_oe_o`=0. This is also the state after reset, and `rd_valid_o`=0 after reset.
- R2: An accepted write produces the following sequence, with the chip selected throughout (`mem_ce1_n_o`=0, `mem_ce2_o`=1). First one cycle with `mem_we_n_o`=1. Then `mem_we_n_o`=0 for exactly WLOW = max(WPULSE_CYC, SETUP_CYC+1) cycles. Then one cycle with `mem_we_n_o`=1. The chip is then deselected and the byte is stored at the address.
- R3: `mem_oe_n_o` stays 1 whenever `mem_we_n_o` is 0 and through every write.
- R4: `mem_dq_oe_o` is 1 only in two places: the last SETUP_CYC cycles of the write-strobe-low phase (never its first cycle), and the one cycle right after the strobe rises. While it is 1, `mem_dq_o` carries the write data.
- R5: `mem_addr_o` takes the request address at acceptance. It does not change until the next acceptance, whatever the host drives on `req_addr_i` meanwhile.
- R6: An accepted read holds the chip selected, `mem_oe_n_o`=0 and `mem_we_n_o`=1 for ACCESS_CYC cycles. It samples `mem_dq_i` at the end of the last of those cycles and raises `rd_valid_o` for one cycle, ACCESS_CYC+1 cycles after acceptance, with `rd_data_o` equal to the sampled byte.
- R7: After each read's access cycles, the memory is deselected for TURN_CYC cycles with `req_ready_o` low before another request can be accepted.
- R8: `req_ready_o` is low from acceptance until the sequence ends. That is WLOW+2 cycles for a write and ACCESS_CYC+TURN_CYC cycles for a read. Each read gives exactly one `rd_valid_o` pulse and a write gives none.
- R9: `mem_dq_oe_o` is never 1 while `mem_oe_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Request byte address |
| req_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | One-cycle pulse with read data |
| rd_data_o | output | 8 | Read data |
| mem_ce1_n_o | output | 1 | Memory chip enable, active low |
| mem_ce2_o | output | 1 | Memory chip enable, active high |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_addr_o | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data to memory bus |
| mem_dq_i | input | 8 | Data from memory bus |
| mem_dq_oe_o | output | 1 | Enable of the data bus driver |

## Verification
The bench models a RAM that shows a filler byte until the output enable has been low for the full access time. A controller that samples too early therefore returns the filler and not the stored byte. The model stores a write only if the driver was on before the strobe rose and still on at that edge. This catches a late data enable or one removed together with the rising strobe. The host moves its address and flips the request type while the controller is busy, and it queues a write directly behind a read. This exposes an address that follows the host, a second acceptance during a busy sequence, and a driver that switches on while the RAM may still be driving the bus.

// File: rtl/sram_bus_ctrl_pkg.sv
package sram_bus_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WEND,
    ST_RACC,
    ST_TURN
  } ctrl_st_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pin_t;

  localparam pin_t PINS_DESEL = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_bus_ctrl_pkg::*;
#(
  parameter int WLOW_CYC   = 2,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1,
  parameter int CNT_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             is_write_i,
  output ctrl_st_e         st_q_o,
  output ctrl_st_e         st_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             rd_last_o
);

  ctrl_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  localparam logic [CNT_W-1:0] WLOW_LAST = CNT_W'(WLOW_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LAST  = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept_i) st_d = is_write_i ? ST_WSET : ST_RACC;
      end
      ST_WSET: begin
        st_d  = ST_WLOW;
        cnt_d = '0;
      end
      ST_WLOW: if (cnt_q == WLOW_LAST) begin
        st_d  = ST_WEND;
        cnt_d = '0;
      end
      ST_WEND: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
      ST_RACC: if (cnt_q == ACC_LAST) begin
        st_d  = ST_TURN;
        cnt_d = '0;
      end
      ST_TURN: if (cnt_q == TURN_LAST) begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_q_o    = st_q;
  assign st_d_o    = st_d;
  assign cnt_d_o   = cnt_d;
  assign rd_last_o = (st_q == ST_RACC) && (cnt_q == ACC_LAST);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_bus_ctrl_pkg::*;
#(
  parameter int WLOW_CYC  = 2,
  parameter int SETUP_CYC = 1,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_st_e         st_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output pin_t             pins_o
);

  // driver turns on for the trailing SETUP_CYC cycles of the strobe (index >= 1)
  localparam logic [CNT_W-1:0] DQ_ON = CNT_W'(WLOW_CYC - SETUP_CYC);

  pin_t pins_d, pins_q;

  always_comb begin
    pins_d = PINS_DESEL;
    unique case (st_d_i)
      ST_WSET: begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
      end
      ST_WLOW: begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
        pins_d.we_n  = 1'b0;
        pins_d.dq_oe = (cnt_d_i >= DQ_ON);
      end
      ST_WEND: begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
        pins_d.dq_oe = 1'b1;
      end
      ST_RACC: begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
        pins_d.oe_n  = 1'b0;
      end
      default: pins_d = PINS_DESEL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= PINS_DESEL;
    else         pins_q <= pins_d;
  end

  assign pins_o = pins_q;

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              rd_last_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= req_addr_i;
      mem_dq_o   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_last_i;
      if (rd_last_i) rd_data_o <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 2,
  parameter int WPULSE_CYC = 2,
  parameter int SETUP_CYC  = 1,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_ce1_n_o,
  output logic              mem_ce2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);

  localparam int WLOW_CYC = (WPULSE_CYC > SETUP_CYC) ? WPULSE_CYC : SETUP_CYC + 1;
  localparam int MAX_A    = (WLOW_CYC > ACCESS_CYC) ? WLOW_CYC : ACCESS_CYC;
  localparam int MAX_CYC  = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctrl_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_d;
  logic             rd_last, accept;
  pin_t             pins;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  sram_ctrl_seq #(
    .WLOW_CYC(WLOW_CYC), .ACCESS_CYC(ACCESS_CYC), .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .is_write_i(req_write_i),
    .st_q_o    (st_q),
    .st_d_o    (st_d),
    .cnt_d_o   (cnt_d),
    .rd_last_o (rd_last)
  );

  sram_ctrl_pins #(
    .WLOW_CYC(WLOW_CYC), .SETUP_CYC(SETUP_CYC), .CNT_W(CNT_W)
  ) u_pins (
    .clk_i, .rst_ni,
    .st_d_i (st_d),
    .cnt_d_i(cnt_d),
    .pins_o (pins)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .req_addr_i,
    .req_wdata_i,
    .rd_last_i  (rd_last),
    .mem_dq_i,
    .mem_addr_o,
    .mem_dq_o,
    .rd_valid_o,
    .rd_data_o
  );

  assign mem_ce1_n_o = pins.ce1_n;
  assign mem_ce2_o   = pins.ce2;
  assign mem_oe_n_o  = pins.oe_n;
  assign mem_we_n_o  = pins.we_n;
  assign mem_dq_oe_o = pins.dq_oe;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rd_valid_o,
  input logic              mem_ce1_n_o,
  input logic              mem_ce2_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o
);

  a_r1_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce1_n_o && !mem_ce2_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

  a_r2_we_only_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_ce1_n_o && mem_ce2_o));

  a_r3_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o);

  a_r4_dq_on_after_we_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (!mem_we_n_o && $past(!mem_we_n_o)));

  a_r4_dq_off_after_we_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_dq_oe_o) |-> (mem_we_n_o && $past(mem_we_n_o)));

  a_r5_addr_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !$past(req_ready_o)) |-> $stable(mem_addr_o));

  a_r6_rd_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r7_turn_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!req_ready_o && mem_oe_n_o && mem_ce1_n_o));

  a_r9_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_n_o));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rd_valid_o (rd_valid_o),
  .mem_ce1_n_o(mem_ce1_n_o),
  .mem_ce2_o  (mem_ce2_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_dq_oe_o(mem_dq_oe_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  ACC   = 3;
  localparam int  WPUL  = 2;
  localparam int  SETUP = 2;
  localparam int  TURN  = 2;
  localparam int  WLOW  = (WPUL > SETUP) ? WPUL : SETUP + 1;
  localparam logic [7:0] FILLER = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data, dq_o, dq_i;
  logic        ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [16:0] maddr;

  sram_bus_ctrl #(
    .ACCESS_CYC(ACC), .WPULSE_CYC(WPUL), .SETUP_CYC(SETUP), .TURN_CYC(TURN)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .mem_ce1_n_o(ce1_n), .mem_ce2_o(ce2), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  // RAM model: 256 bytes keyed by the low address byte
  logic [7:0] ram [0:255];
  int acc_cnt = 0;
  wire sel = !ce1_n && ce2;
  assign dq_i = (sel && !oe_n && we_n && acc_cnt >= ACC) ? ram[maddr[7:0]] : FILLER;

  int n_chk = 0, n_fail = 0;
  int we_run = 0, last_we_len = 0, dq_run = 0, last_dq_len = 0;
  int oe_viol = 0, dq_viol = 0, addr_viol = 0, idle_viol = 0, cont_viol = 0, rd_pulses = 0;
  logic       prev_we_n = 1'b1, prev_dq_oe = 1'b0, prev_busy = 1'b0;
  logic [16:0] prev_addr = '0;
  logic [7:0] exp_wdata = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_we_n = 1'b1; prev_dq_oe = 1'b0; prev_busy = 1'b0; acc_cnt = 0;
    end else begin
      if (sel && !oe_n) acc_cnt++; else acc_cnt = 0;
      if (!we_n && !oe_n) oe_viol++;
      if (dq_oe && !oe_n) cont_viol++;
      if (dq_oe && (prev_we_n || dq_o != exp_wdata)) dq_viol++;
      if (req_ready && (!ce1_n || ce2 || !oe_n || !we_n || dq_oe)) idle_viol++;
      if (!req_ready && prev_busy && maddr != prev_addr) addr_viol++;
      if (rd_valid) rd_pulses++;
      if (!we_n) begin
        we_run++;
        if (dq_oe) dq_run++;
      end else if (!prev_we_n) begin
        last_we_len = we_run; last_dq_len = dq_run; we_run = 0; dq_run = 0;
        ram[maddr[7:0]] = (prev_dq_oe && dq_oe && sel) ? dq_o : 8'hEE;
      end
      prev_we_n = we_n; prev_dq_oe = dq_oe; prev_busy = !req_ready; prev_addr = maddr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // accept at the next posedge, then scramble the request while busy
  task automatic send(input bit wr, input logic [16:0] a, input logic [7:0] d,
                      output int busy, output int lat, output logic [7:0] rdat,
                      output logic [16:0] first_addr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) exp_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
    first_addr = maddr;
    busy = 0; lat = 0; rdat = '0;
    while (!req_ready) begin
      busy++;
      if (rd_valid && lat == 0) begin lat = busy; rdat = rd_data; end
      @(negedge clk);
    end
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    int busy, lat, p0; logic [7:0] r; logic [16:0] fa;
    p0 = rd_pulses;
    send(1'b1, a, d, busy, lat, r, fa);
    chk("R2 we low length", last_we_len, WLOW);
    chk("R2 byte stored", ram[a[7:0]], d);
    chk("R3 oe low during write", oe_viol, 0);
    chk("R4 dq driven cycles", last_dq_len, SETUP);
    chk("R4 dq enable window", dq_viol, 0);
    chk("R5 address loaded", fa, a);
    chk("R5 address held", addr_viol, 0);
    chk("R8 write busy", busy, WLOW + 2);
    chk("R8 no rd pulse on write", rd_pulses, p0);
    chk("R1 idle deselect", idle_viol, 0);
  endtask

  task automatic t_read(input logic [16:0] a);
    int busy, lat, p0; logic [7:0] r; logic [16:0] fa;
    p0 = rd_pulses;
    send(1'b0, a, 8'h00, busy, lat, r, fa);
    chk("R6 read latency", lat, ACC + 1);
    chk("R6 read data", r, ram[a[7:0]]);
    chk("R7 read busy with turn", busy, ACC + TURN);
    chk("R8 one rd pulse", rd_pulses, p0 + 1);
    chk("R9 no contention", cont_viol, 0);
    chk("R5 address loaded", fa, a);
    chk("R1 idle deselect", idle_viol, 0);
  endtask

  // read with a write queued behind it, valid held high
  task automatic t_read_then_write(input logic [16:0] ra, input logic [16:0] wa, input logic [7:0] d);
    int p0, cyc;
    p0 = rd_pulses;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ra;
    @(negedge clk);
    req_write = 1'b1; req_addr = wa; req_wdata = d; exp_wdata = d;
    cyc = 1;
    while (!req_ready) begin @(negedge clk); cyc++; end
    chk("R7 write waits for turnaround", cyc, ACC + TURN + 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk("R8 one rd pulse in pair", rd_pulses, p0 + 1);
    chk("R2 queued write stored", ram[wa[7:0]], d);
    chk("R9 no contention in pair", cont_viol, 0);
    chk("R4 dq window in pair", dq_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", req_ready, 1'b1);
    chk("R1 reset strobes", {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
    chk("R1 reset rd_valid", rd_valid, 1'b0);
    rst_n = 1'b1;
    t_read(17'h00007);
    t_write(17'h10012, 8'hA7);
    t_read(17'h10012);
    t_write(17'h0FF80, 8'h01);
    t_write(17'h1FFFF, 8'hFE);
    t_read(17'h1FFFF);
    t_read(17'h0FF80);
    t_read_then_write(17'h10012, 17'h00033, 8'hC3);
    t_read(17'h00033);
    t_write(17'h00033, 8'h00);
    t_read(17'h00033);
    repeat (3) @(negedge clk);
    chk("R1 final idle", {req_ready, ce1_n, ce2, oe_n, we_n, dq_oe}, 6'b110110);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule